// File: doc/BRIEF.md
# Programmable Up-Counting Event Timer

This block is a general-purpose timer meant to drive an operating-system tick or a single delayed event. Software reaches it over a simple 32-bit register bus with a select, a write strobe and a byte address. Reads are combinational. The timer has a clock divider and an up-counter. Each time the counter rolls over from its reload limit back to zero, the timer raises an update event. That event sets a sticky status flag. When interrupts are enabled, the flag drives a level interrupt line until software acknowledges it.

Software programs the divider value and the reload limit, then starts the counter. In periodic operation the counter keeps running. In single-shot operation the hardware clears the run bit at the first rollover. The reload limit can be buffered, so that a new value waits for the next update event. A software strobe can force an update at any time. It restarts both counting stages and loads the buffered values. The counter width is 16 or 32 bits, chosen when the block is built. Software can find the width by writing all ones to the limit register and reading the value back.

Top module: `upcount_event_timer`

## Requirements
- R1: After reset, every mapped register reads 0 and `irq` is low.
- R2: After a forced update with divider value P and limit A, the first update event after the run bit is set comes (P+1)*(A+1) clocks later, and periodic operation repeats at that interval. A divider value of 1023 divides by 1024.
- R3: A write to the divider register (offset 0x28) reads back at once, but it changes the division only at the next update event.
- R4: With the buffer bit (control bit 7) set, a write to the limit register (offset 0x2C) takes effect at the next update event. With the bit clear, the write takes effect at once.
- R5: With the single-shot bit (control bit 3) set, a rollover clears the run bit (control bit 0). No further update occurs until software sets the run bit again, and the next run is a full period.
- R6: Bit 0 of the status register (offset 0x10) is set by every update event. Writing 0 to it clears it. Writing 1 leaves it unchanged.
- R7: `irq` is high exactly when the status flag is set and bit 0 of the interrupt-enable register (offset 0x0C) is set.
- R8: Writing 1 to bit 0 of the event register (offset 0x14) sets the status flag on the next clock. It also restarts the divider and the counter from 0, so the next update follows one full period later. The event register always reads 0.
- R9: Writing 0 to the control register (offset 0x00) freezes both counting stages. When the run bit is set again, counting resumes from the held count.
- R10: The limit register reads back only CNT_W bits. An all-ones write reads back as 0x0000FFFF in the 16-bit build and as 0xFFFFFFFF in the 32-bit build.
- R11: A read of an address outside the six mapped offsets returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Level interrupt: status flag AND enable |

## Verification
The embedded properties assume one bus access per cycle at a word-aligned address. They also assume that the divider value does not change except through an update event. Software keeps to both by writing the divider only into its buffered copy. The bench drives one access per cycle and always programs a limit of at least 1. This keeps a period longer than one clock, so an acknowledge write never falls in the same cycle as the next rollover. The only exception is a directed check that confirms a set from hardware wins over a clear.

// File: rtl/evt_tmr_pkg.sv
package evt_tmr_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 8;

    // Register offsets
    localparam logic [ADDR_W-1:0] OFS_CTL = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_IEN = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_STS = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_EGR = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_PSC = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_ARR = 8'h2C;

    // Control bit positions
    localparam int CTL_RUN_BIT  = 0;
    localparam int CTL_ONCE_BIT = 3;
    localparam int CTL_BUF_BIT  = 7;

    typedef struct packed {
        logic buf_en;
        logic once;
        logic run;
    } ctl_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTL,
        SEL_IEN,
        SEL_STS,
        SEL_EGR,
        SEL_PSC,
        SEL_ARR
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFS_CTL: s = SEL_CTL;
            OFS_IEN: s = SEL_IEN;
            OFS_STS: s = SEL_STS;
            OFS_EGR: s = SEL_EGR;
            OFS_PSC: s = SEL_PSC;
            OFS_ARR: s = SEL_ARR;
            default: s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic [BUS_W-1:0] ctl_to_word(input ctl_t c);
        logic [BUS_W-1:0] w;
        w = '0;
        w[CTL_RUN_BIT]  = c.run;
        w[CTL_ONCE_BIT] = c.once;
        w[CTL_BUF_BIT]  = c.buf_en;
        return w;
    endfunction

    function automatic ctl_t word_to_ctl(input logic [BUS_W-1:0] w);
        ctl_t c;
        c.run    = w[CTL_RUN_BIT];
        c.once   = w[CTL_ONCE_BIT];
        c.buf_en = w[CTL_BUF_BIT];
        return c;
    endfunction
endpackage

// File: rtl/evt_tmr_prescaler.sv
module evt_tmr_prescaler #(
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic             ug_i,
    input  logic [PSC_W-1:0] psc_i,
    output logic             tick_o
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [PSC_W-1:0] pcnt;

    assign tick_o = run_i && (pcnt == psc_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt <= '0;
        end else if (ug_i) begin
            pcnt <= '0;
        end else if (run_i) begin
            pcnt <= tick_o ? '0 : pcnt + 1'b1;
        end
    end

    // R3: active divider value only changes while the divider restarts
    a_r3_pcnt_in_range: assert property (@(posedge clk) disable iff (rst)
        pcnt <= psc_i);

    // R9: a stopped divider keeps its position
    a_r9_pcnt_frozen: assert property (@(posedge clk) disable iff (rst)
        (!run_i && !ug_i) |=> $stable(pcnt));
endmodule

// File: rtl/evt_tmr_counter.sv
module evt_tmr_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             ug_i,
    input  logic [CNT_W-1:0] arr_i,
    output logic             ovf_o
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [CNT_W-1:0] cnt;
    logic             at_top;

    assign at_top = (cnt == arr_i);
    assign ovf_o  = tick_i && at_top && !ug_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (ug_i) begin
            cnt <= '0;
        end else if (tick_i) begin
            cnt <= at_top ? '0 : cnt + 1'b1;
        end
    end

    // R8: forced update restarts the count
    a_r8_ug_zeroes_count: assert property (@(posedge clk) disable iff (rst)
        ug_i |=> (cnt == '0));

    // R9: without a divider tick the count is held
    a_r9_count_held: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && !ug_i) |=> $stable(cnt));

    // R2: a rollover always lands on zero
    a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
        ovf_o |=> (cnt == '0));
endmodule

// File: rtl/evt_tmr_regs.sv
module evt_tmr_regs
    import evt_tmr_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PSC_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              ovf_i,
    output logic              run_o,
    output logic              ug_o,
    output logic              flag_o,
    output logic              ien_o,
    output logic [PSC_W-1:0]  psc_act_o,
    output logic [CNT_W-1:0]  arr_act_o
);
    timeunit 1ns;
    timeprecision 1ps;

    ctl_t             ctl;
    logic             ien;
    logic             flag;
    logic [PSC_W-1:0] psc_pre;
    logic [PSC_W-1:0] psc_act;
    logic [CNT_W-1:0] arr_pre;
    logic [CNT_W-1:0] arr_act;
    reg_sel_e         sel;
    logic             wr;
    logic             wr_ctl, wr_ien, wr_sts, wr_egr, wr_psc, wr_arr;
    logic             ug;
    logic             upd;
    logic [BUS_W-1:0] psc_word;
    logic [BUS_W-1:0] arr_word;
    logic             unused_wdata;

    assign unused_wdata = ^bus_wdata;

    assign sel    = decode_addr(bus_addr);
    assign wr     = bus_sel && bus_we;
    assign wr_ctl = wr && (sel == SEL_CTL);
    assign wr_ien = wr && (sel == SEL_IEN);
    assign wr_sts = wr && (sel == SEL_STS);
    assign wr_egr = wr && (sel == SEL_EGR);
    assign wr_psc = wr && (sel == SEL_PSC);
    assign wr_arr = wr && (sel == SEL_ARR);
    assign ug     = wr_egr && bus_wdata[0];
    assign upd    = ovf_i || ug;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl     <= '0;
            ien     <= 1'b0;
            flag    <= 1'b0;
            psc_pre <= '0;
            psc_act <= '0;
            arr_pre <= '0;
            arr_act <= '0;
        end else begin
            if (wr_ctl) begin
                ctl <= word_to_ctl(bus_wdata);
            end else if (ovf_i && ctl.once) begin
                ctl.run <= 1'b0;
            end

            if (wr_ien) begin
                ien <= bus_wdata[0];
            end

            if (upd) begin
                flag <= 1'b1;
            end else if (wr_sts) begin
                flag <= flag & bus_wdata[0];
            end

            if (wr_psc) begin
                psc_pre <= bus_wdata[PSC_W-1:0];
            end
            if (upd) begin
                psc_act <= psc_pre;
            end

            if (wr_arr) begin
                arr_pre <= bus_wdata[CNT_W-1:0];
            end
            if (wr_arr && !ctl.buf_en) begin
                arr_act <= bus_wdata[CNT_W-1:0];
            end else if (upd) begin
                arr_act <= arr_pre;
            end
        end
    end

    // Width variants of the readback words
    generate
        if (CNT_W < BUS_W) begin : g_arr_narrow
            assign arr_word = {{(BUS_W-CNT_W){1'b0}}, arr_pre};
        end else begin : g_arr_full
            assign arr_word = arr_pre;
        end
        if (PSC_W < BUS_W) begin : g_psc_narrow
            assign psc_word = {{(BUS_W-PSC_W){1'b0}}, psc_pre};
        end else begin : g_psc_full
            assign psc_word = psc_pre;
        end
    endgenerate

    always_comb begin
        case (sel)
            SEL_CTL: bus_rdata = ctl_to_word(ctl);
            SEL_IEN: bus_rdata = {{(BUS_W-1){1'b0}}, ien};
            SEL_STS: bus_rdata = {{(BUS_W-1){1'b0}}, flag};
            SEL_PSC: bus_rdata = psc_word;
            SEL_ARR: bus_rdata = arr_word;
            default: bus_rdata = '0;
        endcase
    end

    assign run_o     = ctl.run;
    assign ug_o      = ug;
    assign flag_o    = flag;
    assign ien_o     = ien;
    assign psc_act_o = psc_act;
    assign arr_act_o = arr_act;

    // R5: single-shot rollover drops the run bit
    a_r5_once_stops: assert property (@(posedge clk) disable iff (rst)
        (ovf_i && ctl.once && !wr_ctl) |=> !ctl.run);

    // R6: every update leaves the flag set
    a_r6_flag_set: assert property (@(posedge clk) disable iff (rst)
        upd |=> flag);

    // R4: unbuffered limit write is live on the next cycle
    a_r4_direct_limit: assert property (@(posedge clk) disable iff (rst)
        (wr_arr && !ctl.buf_en) |=> (arr_act == $past(bus_wdata[CNT_W-1:0])));

    // R4: buffered limit stays put until an update
    a_r4_buffered_hold: assert property (@(posedge clk) disable iff (rst)
        (!upd && !(wr_arr && !ctl.buf_en)) |=> $stable(arr_act));
endmodule

// File: rtl/upcount_event_timer.sv
module upcount_event_timer
    import evt_tmr_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PSC_W = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_sel,
    input  logic        bus_we,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq
);
    timeunit 1ns;
    timeprecision 1ps;

    logic             run;
    logic             ug;
    logic             flag;
    logic             ien;
    logic             tick;
    logic             ovf;
    logic [PSC_W-1:0] psc_act;
    logic [CNT_W-1:0] arr_act;

    evt_tmr_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ovf_i     (ovf),
        .run_o     (run),
        .ug_o      (ug),
        .flag_o    (flag),
        .ien_o     (ien),
        .psc_act_o (psc_act),
        .arr_act_o (arr_act)
    );

    evt_tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk    (clk),
        .rst    (rst),
        .run_i  (run),
        .ug_i   (ug),
        .psc_i  (psc_act),
        .tick_o (tick)
    );

    evt_tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .tick_i (tick),
        .ug_i   (ug),
        .arr_i  (arr_act),
        .ovf_o  (ovf)
    );

    assign irq = flag && ien;

    // R2: a rollover only happens while the counter runs
    a_r2_ovf_needs_run: assert property (@(posedge clk) disable iff (rst)
        ovf |-> run);
endmodule

// File: tb/upcount_event_timer_bench.sv
module upcount_event_timer_bench;
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [7:0] A_CTL = 8'h00;
    localparam logic [7:0] A_IEN = 8'h0C;
    localparam logic [7:0] A_STS = 8'h10;
    localparam logic [7:0] A_EGR = 8'h14;
    localparam logic [7:0] A_PSC = 8'h28;
    localparam logic [7:0] A_ARR = 8'h2C;
    localparam logic [31:0] C_RUN  = 32'h1;
    localparam logic [31:0] C_ONCE = 32'h8;
    localparam logic [31:0] C_BUF  = 32'h80;
    localparam int LIMIT = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    logic        n_sel = 1'b0;
    logic        n_we = 1'b0;
    logic [7:0]  n_addr = '0;
    logic [31:0] n_wdata = '0;
    logic [31:0] n_rdata;
    logic        n_irq;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    upcount_event_timer #(.CNT_W(32), .PSC_W(16)) u_upcount_event_timer (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    upcount_event_timer #(.CNT_W(16), .PSC_W(16)) u_narrow (
        .clk(clk), .rst(rst), .bus_sel(n_sel), .bus_we(n_we),
        .bus_addr(n_addr), .bus_wdata(n_wdata), .bus_rdata(n_rdata), .irq(n_irq)
    );

    function automatic int exp_period(input int p, input int a);
        return (p + 1) * (a + 1);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    // counts clock edges until irq is seen, starting from 'start'
    task automatic count_to_irq(input int start, output int n);
        logic done;
        done = 1'b0;
        n = start;
        while (!done) begin
            @(posedge clk);
            n++;
            #1;
            if (irq || n >= LIMIT) done = 1'b1;
        end
    endtask

    task automatic time_first(output int n);
        count_to_irq(0, n);
    endtask

    task automatic time_next(output int n);
        wr(A_STS, 32'h0);
        count_to_irq(1, n);
    endtask

    task automatic arm(input int p, input int a);
        wr(A_CTL, 32'h0);
        wr(A_PSC, p);
        wr(A_ARR, a);
        wr(A_EGR, 32'h1);
        wr(A_STS, 32'h0);
        wr(A_IEN, 32'h1);
    endtask

    initial begin
        #(2.5 * 2 * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int n;
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state, R11 unmapped read
        rd(A_CTL, d); chk("R1 ctl", d, 0);
        rd(A_IEN, d); chk("R1 ien", d, 0);
        rd(A_STS, d); chk("R1 sts", d, 0);
        rd(A_EGR, d); chk("R1 egr", d, 0);
        rd(A_PSC, d); chk("R1 psc", d, 0);
        rd(A_ARR, d); chk("R1 arr", d, 0);
        chk("R1 irq", irq, 0);
        rd(8'h04, d); chk("R11 unmapped 04", d, 0);
        rd(8'h24, d); chk("R11 unmapped 24", d, 0);

        // R2 directed periods
        arm(0, 4); wr(A_CTL, C_RUN); time_first(n);
        chk("R2 p0 a4", n, exp_period(0, 4));
        time_next(n); chk("R2 periodic repeat", n, exp_period(0, 4));
        arm(2, 3); wr(A_CTL, C_RUN); time_first(n);
        chk("R2 p2 a3", n, exp_period(2, 3));
        arm(1023, 1); wr(A_CTL, C_RUN); time_first(n);
        chk("R2 div1024", n, exp_period(1023, 1));

        // R6 / R7 flag and interrupt gating
        wr(A_CTL, 32'h0);
        wr(A_STS, 32'h1);
        rd(A_STS, d); chk("R6 write1 keeps flag", d, 1);
        wr(A_IEN, 32'h0);
        chk("R7 irq masked", irq, 0);
        wr(A_IEN, 32'h1);
        chk("R7 irq enabled", irq, 1);
        wr(A_STS, 32'h0);
        rd(A_STS, d); chk("R6 write0 clears", d, 0);
        chk("R7 irq after ack", irq, 0);
        rd(A_EGR, d); chk("R8 egr reads zero", d, 0);

        // R4 buffered limit
        arm(0, 4);
        wr(A_CTL, C_BUF);
        wr(A_ARR, 9);
        rd(A_ARR, d); chk("R4 buffered readback", d, 9);
        wr(A_CTL, C_BUF | C_RUN); time_first(n);
        chk("R4 old limit until update", n, exp_period(0, 4));
        time_next(n); chk("R4 new limit after update", n, exp_period(0, 9));
        // R4 direct limit
        arm(0, 4);
        wr(A_ARR, 6);
        wr(A_CTL, C_RUN); time_first(n);
        chk("R4 direct limit", n, exp_period(0, 6));

        // R3 divider applied at update
        arm(0, 3);
        wr(A_PSC, 2);
        rd(A_PSC, d); chk("R3 psc readback", d, 2);
        wr(A_CTL, C_RUN); time_first(n);
        chk("R3 old divider", n, exp_period(0, 3));
        time_next(n); chk("R3 new divider", n, exp_period(2, 3));

        // R5 single shot
        arm(1, 2);
        wr(A_CTL, C_ONCE | C_RUN); time_first(n);
        chk("R5 once period", n, exp_period(1, 2));
        rd(A_CTL, d); chk("R5 run cleared", d, C_ONCE);
        wr(A_STS, 32'h0);
        repeat (40) @(posedge clk);
        #1; chk("R5 no second update", irq, 0);
        wr(A_CTL, C_ONCE | C_RUN); time_first(n);
        chk("R5 restart full period", n, exp_period(1, 2));

        // R9 stop and resume
        arm(0, 9);
        wr(A_CTL, C_RUN);
        repeat (3) @(posedge clk);
        wr(A_CTL, 32'h0);            // 4 counted edges so far
        repeat (30) @(posedge clk);
        #1; chk("R9 frozen no update", irq, 0);
        wr(A_CTL, C_RUN); time_first(n);
        chk("R9 resume from held", n, exp_period(0, 9) - 4);

        // R8 forced update mid-run
        arm(1, 5);
        wr(A_CTL, C_RUN);
        repeat (5) @(posedge clk);
        wr(A_EGR, 32'h1);
        chk("R8 flag after strobe", irq, 1);
        time_next(n); chk("R8 restart full period", n, exp_period(1, 5));

        // R10 width discovery
        wr(A_CTL, 32'h0);
        wr(A_ARR, 32'hFFFF_FFFF);
        rd(A_ARR, d); chk("R10 32-bit readback", d, 32'hFFFF_FFFF);
        @(negedge clk);
        n_sel = 1'b1; n_we = 1'b1; n_addr = A_ARR; n_wdata = 32'hFFFF_FFFF;
        @(posedge clk); #1;
        n_we = 1'b0;
        @(negedge clk);
        chk("R10 16-bit readback", n_rdata, 32'h0000_FFFF);
        n_sel = 1'b0;

        // randomized periods, modes and buffering
        for (int i = 0; i < 20; i++) begin
            int p, a;
            logic once, bf;
            p = $urandom_range(0, 7);
            a = $urandom_range(1, 25);
            once = 1'($urandom_range(0, 1));
            bf = 1'($urandom_range(0, 1));
            arm(p, a);
            wr(A_CTL, C_RUN | (once ? C_ONCE : 32'h0) | (bf ? C_BUF : 32'h0));
            time_first(n);
            chk("R2 random period", n, exp_period(p, a));
            if (once) begin
                rd(A_CTL, d);
                chk("R5 random once", d[0], 0);
            end else begin
                time_next(n);
                chk("R2 random repeat", n, exp_period(p, a));
            end
        end

        wr(A_CTL, 32'h0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule